// File: doc/BRIEF.md
# Pixel Line Buffer Output Stage

This block is the last stage of a display controller before the video pins. Words of packed colour (red, green, blue) arrive in the system clock domain from the memory-fetch logic and are stored in a dual-clock line FIFO. The pixel clock domain reads one word on every pixel clock in which the display gate (the combined horizontal and vertical active window) is high. The word is then split into its three colour channels and driven out.

The timing generator's sync and blank strobes travel through a matching pipeline, so each strobe leaves the block in the same pixel clock as the colour word that was requested alongside it. When the gate asks for a pixel while the FIFO holds none, an underrun flag is raised in the pixel domain and carried back to the system clock as an interrupt source. Dropping the video enable empties the buffer on both sides.

Top module: `pixbuf_out_stage`

## Requirements
- R1: Two cycles after both resets are released, the colour outputs and the four strobe outputs are 0, `line_empty` is 1, `fetch_full` is 0 and `underrun_irq` is 0.
- R2: Words leave in the order they were written, with red taken from bits 23..16 of `fetch_rgb`, green from bits 15..8 and blue from bits 7..0. A word requested by `disp_gate` sampled high at pixel edge k appears on the colour outputs after pixel edge k+1.
- R3: `hsync_o`, `vsync_o`, `csync_o` and `blank_o` equal the matching input as it was sampled two pixel clock edges earlier.
- R4: After 2^ADDR_W words have been written and none read, `fetch_full` is 1, and a write attempted while `fetch_full` is 1 is dropped and never reaches the output.
- R5: A read requested while `line_empty` is 1 changes neither the read position nor the colour outputs; the next word written is the next word read.
- R6: Each pixel clock, an underrun flag is registered as `disp_gate` AND `line_empty`; it reaches `underrun_irq` through two system-clock flip-flops, and `underrun_irq` stays 0 while every gated read finds data.
- R7: While `video_en` is 0 the buffer is cleared: after it returns to 1, `line_empty` is 1, `fetch_full` is 0, and words written before the clear never appear.
- R8: Positions cross between the clocks in Gray code, changing at most one bit per clock; `line_empty` falls once written data has crossed, and the buffer keeps its order when the positions wrap past the end of storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System (bus) clock, write side |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| video_en | input | 1 | Video enable; 0 clears the buffer |
| fetch_valid | input | 1 | Write strobe for one colour word |
| fetch_rgb | input | 3*COLOR_W | Colour word: red high, green middle, blue low |
| fetch_full | output | 1 | Buffer full, system domain |
| underrun_irq | output | 1 | Underrun flag resampled in the system domain |
| pix_clk | input | 1 | Pixel clock, read side |
| pix_rst_n | input | 1 | Synchronous active-low reset, pixel domain |
| disp_gate | input | 1 | Display active window; requests one word per pixel |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| csync_in | input | 1 | Composite sync from the timing generator |
| blank_in | input | 1 | Blank strobe from the timing generator |
| line_empty | output | 1 | Buffer empty, pixel domain |
| red_o | output | COLOR_W | Red channel |
| green_o | output | COLOR_W | Green channel |
| blue_o | output | COLOR_W | Blue channel |
| hsync_o | output | 1 | Horizontal sync aligned to the colour data |
| vsync_o | output | 1 | Vertical sync aligned to the colour data |
| csync_o | output | 1 | Composite sync aligned to the colour data |
| blank_o | output | 1 | Blank aligned to the colour data |

## Verification
The bench builds the block with ADDR_W = 4, a 16-word buffer, and the default 8-bit colour channels. The small depth lets short bursts fill the buffer, push writes against the full flag and drive both positions past the end of storage within a few dozen words. The pixel clock runs at a period unrelated to the system clock, so the Gray-coded crossings, the underrun resampling and the clear by video enable all see a drifting phase between the two domains.

// File: rtl/pixbuf_pkg.sv
// Shared definitions for the pixel line buffer output stage.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package pixbuf_pkg;

    // Number of pixel-clock registers between the strobe inputs and outputs;
    // equals the read latency of the buffer plus its output register.
    localparam int unsigned STROBE_STAGES = 2;

    // Bundle of the timing strobes that travel beside the colour data.
    typedef struct packed {
        logic hs;
        logic vs;
        logic cs;
        logic blank;
    } strobe_t;

    localparam int unsigned STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/pixbuf_sync.sv
// Two-flop resynchroniser for a vector that is stable or Gray-coded.
// Assumes the source changes at most one bit between destination edges
// when WIDTH > 1. Reset is synchronous, active low, and clears to zero.
module pixbuf_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Capture the foreign-domain value, then let it settle one more cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;

endmodule

// File: rtl/pixbuf_align.sv
// Fixed-latency register pipeline used to keep strobes and colour data
// in step. STAGES picks a single register or a shift chain.
// Assumes STAGES >= 1. Reset is synchronous, active low, clears to zero.
module pixbuf_align #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] hold_q;

            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) hold_q <= '0;
                else        hold_q <= d;
            end

            assign q = hold_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_q;

            // Shift the value one stage deeper every clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end

            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pixbuf_afifo.sv
// Dual-clock FIFO with registered read data. Positions are kept in
// binary locally and passed across domains as Gray codes through
// two-flop resynchronisers. Full is judged on the write side, empty on
// the read side, each from its own position and the resynchronised
// far position. Writes when full and reads when empty are dropped.
// Assumes ADDR_W >= 2 and that each side's clear is held long enough
// for the other side's clear to overlap it.
module pixbuf_afifo #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              wr_clk,
    input  logic              wr_clr_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,

    input  logic              rd_clk,
    input  logic              rd_clr_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PTR_W = ADDR_W + 1;

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [DATA_W-1:0] store [DEPTH];

    // ---------------- write side ----------------
    logic [PTR_W-1:0] wbin_q, wgray_q, wbin_nxt;
    logic [PTR_W-1:0] rgray_at_w;
    logic             wr_take;

    assign wbin_nxt = wbin_q + 1'b1;
    assign wr_take  = wr_en && !wr_full;

    // Full when the write position is one lap ahead of the read position.
    assign wr_full = (wgray_q == {~rgray_at_w[PTR_W-1 -: 2], rgray_at_w[PTR_W-3:0]});

    // Advance the write position on an accepted write.
    always_ff @(posedge wr_clk) begin
        if (!wr_clr_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_take) begin
            wbin_q  <= wbin_nxt;
            wgray_q <= to_gray(wbin_nxt);
        end
    end

    // Store the accepted word.
    always_ff @(posedge wr_clk) begin
        if (wr_take) store[wbin_q[ADDR_W-1:0]] <= wr_data;
    end

    // ---------------- read side ----------------
    logic [PTR_W-1:0] rbin_q, rgray_q, rbin_nxt;
    logic [PTR_W-1:0] wgray_at_r;
    logic             rd_take;

    assign rbin_nxt = rbin_q + 1'b1;
    assign rd_empty = (rgray_q == wgray_at_r);
    assign rd_take  = rd_en && !rd_empty;

    // Advance the read position and register the word on a served read.
    always_ff @(posedge rd_clk) begin
        if (!rd_clr_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            rd_data <= '0;
        end else if (rd_take) begin
            rbin_q  <= rbin_nxt;
            rgray_q <= to_gray(rbin_nxt);
            rd_data <= store[rbin_q[ADDR_W-1:0]];
        end
    end

    // ---------------- crossings ----------------
    pixbuf_sync #(.WIDTH(PTR_W)) u_rptr_to_w (
        .clk   (wr_clk),
        .rst_n (wr_clr_n),
        .d     (rgray_q),
        .q     (rgray_at_w)
    );

    pixbuf_sync #(.WIDTH(PTR_W)) u_wptr_to_r (
        .clk   (rd_clk),
        .rst_n (rd_clr_n),
        .d     (wgray_q),
        .q     (wgray_at_r)
    );

    // ---------------- assertions ----------------
    // R4
    full_write_dropped_chk: assert property (@(posedge wr_clk) disable iff (!wr_clr_n)
        (wr_en && wr_full) |=> $stable(wbin_q));

    // R5
    empty_read_dropped_chk: assert property (@(posedge rd_clk) disable iff (!rd_clr_n)
        (rd_en && rd_empty) |=> ($stable(rbin_q) && $stable(rd_data)));

    // R8
    wgray_one_bit_chk: assert property (@(posedge wr_clk) disable iff (!wr_clr_n)
        $past(wr_clr_n) |-> $onehot0(wgray_q ^ $past(wgray_q)));

    // R8
    rgray_one_bit_chk: assert property (@(posedge rd_clk) disable iff (!rd_clr_n)
        $past(rd_clr_n) |-> $onehot0(rgray_q ^ $past(rgray_q)));

endmodule

// File: rtl/pixbuf_underrun.sv
// Underrun detector: registers "gate while empty" in the pixel domain
// and resamples it into the system domain through two flip-flops.
// Assumes a flagged pixel-domain level lasts long enough for the system
// clock to see it (pixel clock no faster than the system clock).
module pixbuf_underrun (
    input  logic pix_clk,
    input  logic pix_rst_n,
    input  logic gate,
    input  logic empty,
    input  logic sys_clk,
    input  logic sys_rst_n,
    output logic irq
);

    logic starve_q;

    // Flag every pixel in which a word was wanted but none was held.
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) starve_q <= 1'b0;
        else            starve_q <= gate && empty;
    end

    pixbuf_sync #(.WIDTH(1)) u_starve_to_sys (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (starve_q),
        .q     (irq)
    );

endmodule

// File: rtl/pixbuf_out_stage.sv
// Pixel line buffer output stage. Takes colour words from the fetch side
// in the system domain, releases one per gated pixel clock, and delays
// the timing strobes so they leave beside the matching word. Reports
// read underruns back to the system domain.
// Assumes: video_en is a system-domain level held at least a few pixel
// clocks whenever it changes; disp_gate and the strobes are pixel-domain.
module pixbuf_out_stage
    import pixbuf_pkg::*;
#(
    parameter int unsigned COLOR_W = 8,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                 sys_clk,
    input  logic                 sys_rst_n,
    input  logic                 video_en,
    input  logic                 fetch_valid,
    input  logic [3*COLOR_W-1:0] fetch_rgb,
    output logic                 fetch_full,
    output logic                 underrun_irq,
    input  logic                 pix_clk,
    input  logic                 pix_rst_n,
    input  logic                 disp_gate,
    input  logic                 hsync_in,
    input  logic                 vsync_in,
    input  logic                 csync_in,
    input  logic                 blank_in,
    output logic                 line_empty,
    output logic [COLOR_W-1:0]   red_o,
    output logic [COLOR_W-1:0]   green_o,
    output logic [COLOR_W-1:0]   blue_o,
    output logic                 hsync_o,
    output logic                 vsync_o,
    output logic                 csync_o,
    output logic                 blank_o
);

    localparam int unsigned DATA_W = 3 * COLOR_W;

    // Video enable seen in the pixel domain, then the two clears.
    logic video_en_pix;
    logic wr_clr_n;
    logic rd_clr_n;

    pixbuf_sync #(.WIDTH(1)) u_en_to_pix (
        .clk   (pix_clk),
        .rst_n (pix_rst_n),
        .d     (video_en),
        .q     (video_en_pix)
    );

    assign wr_clr_n = sys_rst_n && video_en;
    assign rd_clr_n = pix_rst_n && video_en_pix;

    // Line buffer.
    logic [DATA_W-1:0] fifo_word;

    pixbuf_afifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_line_fifo (
        .wr_clk   (sys_clk),
        .wr_clr_n (wr_clr_n),
        .wr_en    (fetch_valid),
        .wr_data  (fetch_rgb),
        .wr_full  (fetch_full),
        .rd_clk   (pix_clk),
        .rd_clr_n (rd_clr_n),
        .rd_en    (disp_gate),
        .rd_data  (fifo_word),
        .rd_empty (line_empty)
    );

    // Output register for the colour word (second stage of the read path).
    logic [DATA_W-1:0] pix_word;

    pixbuf_align #(.WIDTH(DATA_W), .STAGES(STROBE_STAGES - 1)) u_word_reg (
        .clk   (pix_clk),
        .rst_n (pix_rst_n),
        .d     (fifo_word),
        .q     (pix_word)
    );

    assign red_o   = pix_word[3*COLOR_W-1 -: COLOR_W];
    assign green_o = pix_word[2*COLOR_W-1 -: COLOR_W];
    assign blue_o  = pix_word[COLOR_W-1:0];

    // Strobe pipeline matched to the read path.
    strobe_t strobe_in;
    strobe_t strobe_out;

    assign strobe_in = '{hs: hsync_in, vs: vsync_in, cs: csync_in, blank: blank_in};

    pixbuf_align #(.WIDTH(STROBE_W), .STAGES(STROBE_STAGES)) u_strobe_pipe (
        .clk   (pix_clk),
        .rst_n (pix_rst_n),
        .d     (strobe_in),
        .q     (strobe_out)
    );

    assign hsync_o = strobe_out.hs;
    assign vsync_o = strobe_out.vs;
    assign csync_o = strobe_out.cs;
    assign blank_o = strobe_out.blank;

    // Underrun detection and return to the system domain.
    pixbuf_underrun u_underrun (
        .pix_clk   (pix_clk),
        .pix_rst_n (pix_rst_n),
        .gate      (disp_gate),
        .empty     (line_empty),
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .irq       (underrun_irq)
    );

    // ---------------- assertions ----------------
    logic [1:0] warm_q;

    // Count pixel clocks since reset, saturating once the pipe is primed.
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n)       warm_q <= '0;
        else if (warm_q != 2) warm_q <= warm_q + 1'b1;
    end

    // R3
    strobe_latency_chk: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        (warm_q == 2) |-> ({hsync_o, vsync_o, csync_o, blank_o} ==
                           $past({hsync_in, vsync_in, csync_in, blank_in}, 2)));

endmodule

// File: tb/tb_pixbuf_out_stage.sv
// Scoreboard bench: a write task queues expected words, the pixel-clock
// process drives the gate and strobes and compares what comes out.
module tb_pixbuf_out_stage;

    localparam int unsigned CW = 8;
    localparam int unsigned AW = 4;
    localparam int unsigned DEPTH = 1 << AW;

    logic          sys_clk = 0, pix_clk = 0;
    logic          sys_rst_n = 0, pix_rst_n = 0;
    logic          video_en = 1;
    logic          fetch_valid = 0;
    logic [3*CW-1:0] fetch_rgb = '0;
    logic          fetch_full, underrun_irq, line_empty;
    logic          disp_gate = 0, hsync_in = 0, vsync_in = 0, csync_in = 0, blank_in = 0;
    logic [CW-1:0] red_o, green_o, blue_o;
    logic          hsync_o, vsync_o, csync_o, blank_o;

    always #5 sys_clk = ~sys_clk;
    always #7 pix_clk = ~pix_clk;

    pixbuf_out_stage #(.COLOR_W(CW), .ADDR_W(AW)) dut (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .video_en(video_en),
        .fetch_valid(fetch_valid), .fetch_rgb(fetch_rgb), .fetch_full(fetch_full),
        .underrun_irq(underrun_irq), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
        .disp_gate(disp_gate), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .csync_in(csync_in), .blank_in(blank_in), .line_empty(line_empty),
        .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o), .blank_o(blank_o)
    );

    int n_run = 0, n_fail = 0;
    logic [3*CW-1:0] exp_q[$];
    logic [3*CW-1:0] last_exp = '0;
    int  reads_todo = 0;
    bit  under_mode = 0;
    bit  drive_on = 0;
    int  irq_hits = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one colour word written on the system side.
    task automatic push_word(input logic [3*CW-1:0] d, input bit keep);
        @(negedge sys_clk);
        fetch_valid = 1; fetch_rgb = d;
        @(negedge sys_clk);
        fetch_valid = 0;
        if (keep) exp_q.push_back(d);
    endtask

    // Ask the pixel process for n gated reads and wait until they are out.
    task automatic pix_read(input int n, input bit under);
        under_mode = under;
        reads_todo = n;
        wait (reads_todo == 0);
        repeat (4) @(negedge pix_clk);
        under_mode = 0;
    endtask

    // Count system cycles with the interrupt source high.
    always @(negedge sys_clk) if (underrun_irq === 1'b1) irq_hits++;

    // Pixel-domain monitor and driver.
    initial begin
        logic       g1 = 0, g2 = 0, u1 = 0, u2 = 0;
        logic [3:0] s1 = 0, s2 = 0;
        int         phase = 0;
        int         cnt = 0;
        forever begin
            @(negedge pix_clk);
            if (drive_on) begin
                // R3: strobes show the inputs driven two pixel clocks ago
                chk("R3", {hsync_o, vsync_o, csync_o, blank_o}, s2);
                if (g2) begin
                    if (u2) begin
                        // R5: read of an empty buffer leaves the colour unchanged
                        chk("R5", {red_o, green_o, blue_o}, last_exp);
                    end else if (exp_q.size() == 0) begin
                        chk("R2", 32'hdead, 32'h0);
                    end else begin
                        last_exp = exp_q.pop_front();
                        // R2: order, channel split, two-clock latency
                        chk("R2", {red_o, green_o, blue_o}, last_exp);
                    end
                end
                g2 = g1; u2 = u1; s2 = s1;
                if (reads_todo > 0 && (phase % 3) != 2) begin
                    disp_gate = 1; reads_todo--;
                end else begin
                    disp_gate = 0;
                end
                phase++;
                cnt++;
                {hsync_in, vsync_in, csync_in, blank_in} = cnt[3:0] ^ cnt[7:4] ^ {cnt[1], 3'b0};
                g1 = disp_gate; u1 = under_mode;
                s1 = {hsync_in, vsync_in, csync_in, blank_in};
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (6) @(negedge sys_clk);
        sys_rst_n = 1; pix_rst_n = 1;
        repeat (2) @(negedge pix_clk);
        // R1: reset state
        chk("R1", {red_o, green_o, blue_o}, 0);
        chk("R1", {hsync_o, vsync_o, csync_o, blank_o}, 0);
        chk("R1", line_empty, 1);
        chk("R1", fetch_full, 0);
        chk("R1", underrun_irq, 0);
        drive_on = 1;
        repeat (4) @(negedge pix_clk);
        irq_hits = 0;

        // Basic transfer of five words with gaps in the gate.
        push_word(24'hA1B2C3, 1);
        push_word(24'h00FF00, 1);
        push_word(24'hFF0000, 1);
        push_word(24'h0000FF, 1);
        push_word(24'h123456, 1);
        repeat (8) @(negedge pix_clk);
        // R8: data crossed, buffer no longer empty
        chk("R8", line_empty, 0);
        pix_read(5, 0);
        chk("R8", line_empty, 1);
        repeat (10) @(negedge sys_clk);

        // Fill to capacity; positions wrap past the end of storage.
        for (int i = 0; i < DEPTH; i++) push_word({8'(i * 7), 8'(255 - i), 8'(i * 16 + 3)}, 1);
        // R4: full after DEPTH unread words
        chk("R4", fetch_full, 1);
        push_word(24'hBADBAD, 0);
        push_word(24'hBADBAE, 0);
        chk("R4", fetch_full, 1);
        repeat (8) @(negedge pix_clk);
        pix_read(DEPTH, 0);
        // R8: wrapped order preserved and buffer drained
        chk("R8", line_empty, 1);
        chk("R4", exp_q.size(), 0);
        // R6: no underrun while every read found data
        chk("R6", irq_hits, 0);

        // Underrun: gate high with nothing stored.
        pix_read(3, 1);
        chk("R6", irq_hits > 0, 1);
        repeat (6) @(negedge sys_clk);
        chk("R6", underrun_irq, 0);
        push_word(24'h5A5A5A, 1);
        repeat (8) @(negedge pix_clk);
        // R5: next write is next read after the dropped reads
        pix_read(1, 0);
        chk("R5", exp_q.size(), 0);
        repeat (10) @(negedge sys_clk);

        // Clear by video enable with data held.
        push_word(24'h111111, 0);
        push_word(24'h222222, 0);
        push_word(24'h333333, 0);
        repeat (8) @(negedge pix_clk);
        chk("R7", line_empty, 0);
        @(negedge sys_clk) video_en = 0;
        repeat (6) @(negedge sys_clk);
        video_en = 1;
        repeat (10) @(negedge pix_clk);
        // R7: cleared buffer
        chk("R7", line_empty, 1);
        chk("R7", fetch_full, 0);

        // Clear by video enable with the buffer full.
        for (int i = 0; i < DEPTH; i++) push_word(24'h777700 + 24'(i), 0);
        chk("R7", fetch_full, 1);
        @(negedge sys_clk) video_en = 0;
        @(negedge sys_clk);
        chk("R7", fetch_full, 0);
        repeat (5) @(negedge sys_clk);
        video_en = 1;
        repeat (10) @(negedge pix_clk);
        chk("R7", line_empty, 1);
        push_word(24'hC0FFEE, 1);
        repeat (8) @(negedge pix_clk);
        // R7: only the word written after the clear comes out
        pix_read(1, 0);
        chk("R7", exp_q.size(), 0);
        chk("R7", {red_o, green_o, blue_o}, 24'hC0FFEE);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule